// File: doc/BRIEF.md
# Station Address PROM Signature Scanner

This block pulls bytes one at a time from a serial station-address PROM. That kind of PROM has an internal read pointer that moves forward on every read strobe, and the pointer's position at power-up is unknown. A start pulse launches a hunt for a fixed eight-byte marker, `FF 00 55 AA FF 00 55 AA`. The hunt is limited to a window of reads long enough to wrap past any starting position: 32 probe positions plus seven more reads, so 39 reads in all. The hunt stops on the exact read that completes the marker. After that the PROM pointer sits on the first byte of the station address.

Once the marker is found, the block reads six address bytes and then two stored checksum bytes. It computes a folded 16-bit sum over the address and compares it with the stored value. Each scan ends with a one-cycle done pulse. Found or not-found, the captured address and a checksum-good flag are then held until the next start. A checksum mismatch is only flagged: the address is still reported.

Top module: `prom_sig_scan`

## Requirements
- R1: After reset, `rd_o`, `done_o`, `found_o`, `not_found_o` and `csum_ok_o` are low and `mac_o` is zero.
- R2: A `start_i` pulse begins a scan. While a scan runs, `rd_o` is high and one PROM byte is consumed on every clock edge. A start that arrives mid-scan discards the scan in progress and restarts from match position zero. The byte present on that restart edge is ignored.
- R3: If the marker is not completed within 39 reads, the block stops reading after exactly 39 reads and signals not-found. In that case `mac_o` stays zero and `csum_ok_o` stays low.
- R4: On a byte that does not match the expected marker byte, the match position becomes 1 if the byte is `FF` and 0 otherwise.
- R5: The hunt ends on the read that completes the marker. The next six reads are the address, with the first byte read placed in `mac_o[7:0]` and the sixth in `mac_o[47:40]`. Then two checksum reads follow, low byte first. A found scan therefore uses marker-end position + 9 reads.
- R6: Address bytes pair into three words, low byte first. For each word the running sum (starting at 0) is doubled and folded, then the word is added and the result is folded again. Folding subtracts `FFFF` from any value above `FFFF`.
- R7: A final sum of exactly `FFFF` is compared as `0000`.
- R8: `csum_ok_o` is high when the folded sum equals the stored checksum and low otherwise. On a mismatch the address is still reported with `found_o` high.
- R9: `done_o` is high for exactly one cycle per finished scan. Exactly one of `found_o` and `not_found_o` is then high, and it stays high until the next start. `rd_o` is low once the scan is done.
- R10: A marker whose last byte is the 39th read is still found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin or restart a scan |
| rd_o | output | 1 | Read strobe; the PROM advances its pointer on each edge where this is high |
| rd_data_i | input | 8 | Byte at the PROM's current pointer |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| found_o | output | 1 | Marker found, address captured |
| not_found_o | output | 1 | Read window used up without a marker |
| mac_o | output | 48 | Captured station address, first byte read in bits 7:0 |
| csum_ok_o | output | 1 | Folded sum equals the stored checksum |

## Verification
The hardest conditions to reach are the partial-restart path and the window edge. The partial-restart path needs a marker occurrence that begins on the very byte that broke a longer partial match. The window edge needs a marker whose final byte lands on read 39, and another that ends one read too late. The bench places PROM images at hand-chosen offsets for each case. It also places address words chosen so that the doubling step overflows and folds, and so that the final sum is exactly `FFFF`. A second start pulse is issued a few reads into a scan to exercise the restart with a PROM pointer that has already moved.

// File: rtl/prom_scan_pkg.sv
package prom_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_ADDR = 2'd2,
        ST_SUM  = 2'd3
    } scan_st_e;

    // Marker byte at position i (four-byte period)
    function automatic logic [7:0] sig_byte(input int i);
        case (i % 4)
            0:       return 8'hFF;
            1:       return 8'h00;
            2:       return 8'h55;
            default: return 8'hAA;
        endcase
    endfunction

    // End-around fold of a 17-bit value into 16 bits
    function automatic logic [15:0] fold17(input logic [16:0] v);
        logic [16:0] t;
        t = (v > 17'h0FFFF) ? (v - 17'h0FFFF) : v;
        return t[15:0];
    endfunction

endpackage

// File: rtl/prom_sig_match.sv
module prom_sig_match
    import prom_scan_pkg::*;
#(
    parameter int SIG_LEN = 8,
    parameter int IW      = $clog2(SIG_LEN + 1)
) (
    input  logic [IW-1:0] idx_i,
    input  logic [7:0]    byte_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);

    logic [7:0] tab [SIG_LEN];
    logic [7:0] expect_b;

    for (genvar g = 0; g < SIG_LEN; g++) begin : g_tab
        assign tab[g] = sig_byte(g);
    end

    always_comb begin
        expect_b = 8'h00;
        for (int k = 0; k < SIG_LEN; k++) begin
            if (idx_i == IW'(k)) expect_b = tab[k];
        end
        if (byte_i == expect_b)
            idx_o = idx_i + IW'(1);
        else if (byte_i == tab[0])
            idx_o = IW'(1);
        else
            idx_o = '0;
        hit_o = (idx_o == IW'(SIG_LEN));
    end

endmodule

// File: rtl/prom_csum_step.sv
module prom_csum_step
    import prom_scan_pkg::*;
(
    input  logic [15:0] acc_i,
    input  logic [15:0] word_i,
    output logic [15:0] acc_o
);

    logic [15:0] dbl_f;
    logic [16:0] sum_w;

    always_comb begin
        dbl_f = fold17({acc_i, 1'b0});
        sum_w = {1'b0, dbl_f} + {1'b0, word_i};
        acc_o = fold17(sum_w);
    end

endmodule

// File: rtl/prom_sig_scan.sv
module prom_sig_scan
    import prom_scan_pkg::*;
#(
    parameter int SIG_LEN    = 8,
    parameter int PROBE_LEN  = 32,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic                    rd_o,
    input  logic [7:0]              rd_data_i,
    output logic                    done_o,
    output logic                    found_o,
    output logic                    not_found_o,
    output logic [ADDR_BYTES*8-1:0] mac_o,
    output logic                    csum_ok_o
);

    localparam int WIN = PROBE_LEN + SIG_LEN - 1;
    localparam int CW  = $clog2(WIN + 1);
    localparam int IW  = $clog2(SIG_LEN + 1);
    localparam int MW  = ADDR_BYTES * 8;
    localparam int RCW = $clog2(WIN + ADDR_BYTES + 3) + 1;

    typedef struct packed {
        scan_st_e      st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [15:0]   acc;
        logic [7:0]    lo;
        logic [MW-1:0] mac;
        logic          done;
        logic          found;
        logic          miss;
        logic          ok;
    } regs_t;

    regs_t q, d;

    logic [IW-1:0] idx_nxt;
    logic          sig_hit;
    logic [15:0]   acc_nxt;
    logic [15:0]   sum_fin;

    prom_sig_match #(.SIG_LEN(SIG_LEN), .IW(IW)) u_match (
        .idx_i  (q.idx),
        .byte_i (rd_data_i),
        .idx_o  (idx_nxt),
        .hit_o  (sig_hit)
    );

    prom_csum_step u_step (
        .acc_i  (q.acc),
        .word_i ({rd_data_i, q.lo}),
        .acc_o  (acc_nxt)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        sum_fin = (q.acc == 16'hFFFF) ? 16'h0000 : q.acc;
        if (start_i) begin
            d.st    = ST_HUNT;
            d.cnt   = '0;
            d.idx   = '0;
            d.acc   = '0;
            d.lo    = '0;
            d.mac   = '0;
            d.found = 1'b0;
            d.miss  = 1'b0;
            d.ok    = 1'b0;
        end else begin
            case (q.st)
                ST_HUNT: begin
                    d.idx = idx_nxt;
                    if (sig_hit) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                        d.idx = '0;
                    end else if (q.cnt == CW'(WIN - 1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.miss = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_ADDR: begin
                    for (int k = 0; k < ADDR_BYTES; k++) begin
                        if (q.cnt == CW'(k)) d.mac[8*k +: 8] = rd_data_i;
                    end
                    if (q.cnt[0] == 1'b0)
                        d.lo = rd_data_i;
                    else
                        d.acc = acc_nxt;
                    if (q.cnt == CW'(ADDR_BYTES - 1)) begin
                        d.st  = ST_SUM;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_SUM: begin
                    if (q.cnt == '0) begin
                        d.lo  = rd_data_i;
                        d.cnt = CW'(1);
                    end else begin
                        d.ok    = (sum_fin == {rd_data_i, q.lo});
                        d.found = 1'b1;
                        d.done  = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_o        = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign found_o     = q.found;
    assign not_found_o = q.miss;
    assign mac_o       = q.mac;
    assign csum_ok_o   = q.ok;

    // Read counter kept only for the window checks below
    logic [RCW-1:0] rd_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_cnt_q <= '0;
        else if (start_i) rd_cnt_q <= '0;
        else if (rd_o)    rd_cnt_q <= rd_cnt_q + RCW'(1);
    end

    assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && not_found_o) |-> (rd_cnt_q == RCW'(WIN)));

    assert_miss_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && not_found_o) |-> (mac_o == '0 && !csum_ok_o));

    assert_found_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (rd_cnt_q >= RCW'(SIG_LEN + ADDR_BYTES + 2)
                                 && rd_cnt_q <= RCW'(WIN + ADDR_BYTES + 2)));

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HUNT) |-> (q.idx < IW'(SIG_LEN)));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o != not_found_o));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_o && !start_i) |=> ($stable(found_o) && $stable(mac_o) && $stable(csum_ok_o)));

endmodule

// File: tb/tb_prom_sig_scan.sv
module tb_prom_sig_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_o;
    logic [7:0]  rd_data;
    logic        done_o, found_o, not_found_o, csum_ok_o;
    logic [47:0] mac_o;

    always #10 clk = ~clk;

    prom_sig_scan dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_o(rd_o),
        .rd_data_i(rd_data), .done_o(done_o), .found_o(found_o),
        .not_found_o(not_found_o), .mac_o(mac_o), .csum_ok_o(csum_ok_o)
    );

    // PROM model
    logic [7:0] rom [0:127];
    int ptr = 0;
    assign rd_data = rom[ptr & 127];

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int rcount = 0;

    // Reference model state
    int          m_phase = 0;   // 0 idle, 1 hunt, 2 address, 3 checksum
    int          m_idx = 0, m_cnt = 0;
    logic [47:0] m_mac = '0;
    logic [7:0]  m_st0 = 0, m_st1 = 0;
    bit          m_done = 0, m_found = 0, m_nf = 0, m_ok = 0;
    logic [7:0]  sig [8] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA};

    function automatic logic [15:0] ref_sum(input logic [47:0] a);
        int s = 0;
        for (int w = 0; w < 3; w++) begin
            s = s * 2;
            if (s > 65535) s = s - 65535;
            s = s + int'(a[16*w +: 16]);
            if (s > 65535) s = s - 65535;
        end
        if (s == 65535) s = 0;
        return 16'(s);
    endfunction

    always @(posedge clk) begin
        logic [7:0] b;
        b = rom[ptr & 127];
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_cnt = 0; m_mac = '0;
            m_done = 0; m_found = 0; m_nf = 0; m_ok = 0;
        end else begin
            m_done = 0;
            if (start_i) begin
                m_phase = 1; m_idx = 0; m_cnt = 0; m_mac = '0;
                m_found = 0; m_nf = 0; m_ok = 0;
            end else if (m_phase == 1) begin
                m_cnt++;
                if (b == sig[m_idx]) m_idx++;
                else m_idx = (b == 8'hFF) ? 1 : 0;
                if (m_idx == 8) begin
                    m_phase = 2; m_cnt = 0;
                end else if (m_cnt == 39) begin
                    m_phase = 0; m_done = 1; m_nf = 1;
                end
            end else if (m_phase == 2) begin
                m_mac[8*m_cnt +: 8] = b;
                m_cnt++;
                if (m_cnt == 6) begin m_phase = 3; m_cnt = 0; end
            end else if (m_phase == 3) begin
                if (m_cnt == 0) begin
                    m_st0 = b; m_cnt = 1;
                end else begin
                    m_st1 = b; m_phase = 0; m_done = 1; m_found = 1;
                    m_ok = (ref_sum(m_mac) == {m_st1, m_st0});
                end
            end
        end
        if (start_i) rcount = 0;
        else if (rd_o) rcount++;
        if (rd_o) ptr = ptr + 1;
    end

    task automatic chk(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_o == (m_phase != 0), "R2 rd_o", 64'(rd_o), 64'(m_phase != 0));
            chk(done_o == m_done, "R9 done_o", 64'(done_o), 64'(m_done));
            chk(found_o == m_found && not_found_o == m_nf, "R3/R5 found",
                {found_o, not_found_o}, {m_found, m_nf});
            chk(mac_o == m_mac, "R5 mac_o", 64'(mac_o), 64'(m_mac));
            chk(csum_ok_o == m_ok, "R8 csum_ok_o", 64'(csum_ok_o), 64'(m_ok));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 128; i++) rom[i] = v;
        ptr = 0;
    endtask

    task automatic put_frame(input int at, input logic [47:0] a, input logic [15:0] cs);
        for (int i = 0; i < 8; i++) rom[at + i] = sig[i];
        for (int i = 0; i < 6; i++) rom[at + 8 + i] = a[8*i +: 8];
        rom[at + 14] = cs[7:0];
        rom[at + 15] = cs[15:8];
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, req, 64'(done_o), 64'd1);
    endtask

    task automatic expect_found(input string req, input logic [47:0] a, input bit ok,
                                input int reads);
        chk(found_o && !not_found_o, req, {found_o, not_found_o}, 2'b10);
        chk(mac_o == a, req, 64'(mac_o), 64'(a));
        chk(csum_ok_o == ok, req, 64'(csum_ok_o), 64'(ok));
        chk(rcount == reads, req, 64'(rcount), 64'(reads));
    endtask

    initial begin
        fill(8'h11);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!rd_o && !done_o && !found_o && !not_found_o && !csum_ok_o && mac_o == 0,
            "R1 reset", {rd_o, done_o, found_o, not_found_o, csum_ok_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6: marker at position 0, plain checksum 0x0578
        fill(8'h11);
        put_frame(0, 48'h0302_012B_0008, 16'h0578);
        pulse_start();
        wait_done("R5 done");
        expect_found("R6 basic", 48'h0302_012B_0008, 1'b1, 16);

        // R9: pulse width and hold
        @(negedge clk);
        chk(!done_o && found_o && !rd_o, "R9 hold", {done_o, found_o, rd_o}, 3'b010);

        // R4: partial match broken by FF that begins the real marker
        fill(8'h11);
        rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55;
        put_frame(3, 48'h0302_012B_0008, 16'h0578);
        pulse_start();
        wait_done("R4 done");
        expect_found("R4 ff restart", 48'h0302_012B_0008, 1'b1, 19);

        // R4: partial match broken by a non-FF byte
        fill(8'h11);
        put_frame(8, 48'h0302_012B_0008, 16'h0578);
        rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55; rom[3] = 8'hAA;
        rom[4] = 8'hFF; rom[5] = 8'h00; rom[6] = 8'h55; rom[7] = 8'h11;
        pulse_start();
        wait_done("R4 done2");
        expect_found("R4 zero restart", 48'h0302_012B_0008, 1'b1, 24);

        // R3: marker begins one read too late
        fill(8'h11);
        put_frame(32, 48'h0302_012B_0008, 16'h0578);
        pulse_start();
        wait_done("R3 done");
        chk(not_found_o && !found_o, "R3 miss", {found_o, not_found_o}, 2'b01);
        chk(mac_o == 0 && !csum_ok_o, "R3 no capture", 64'(mac_o), 0);
        chk(rcount == 39, "R3 window", 64'(rcount), 39);
        repeat (3) @(negedge clk);
        chk(rcount == 39 && !rd_o, "R3 stopped", 64'(rcount), 39);

        // R10: marker ending on read 39
        fill(8'h11);
        put_frame(31, 48'h0302_012B_0008, 16'h0578);
        pulse_start();
        wait_done("R10 done");
        expect_found("R10 edge", 48'h0302_012B_0008, 1'b1, 47);

        // R6: folding in the doubling step
        fill(8'h11);
        put_frame(0, 48'h0001_0002_FFFF, 16'h0005);
        pulse_start();
        wait_done("R6 done");
        expect_found("R6 fold", 48'h0001_0002_FFFF, 1'b1, 16);

        // R7: final FFFF compared as zero
        fill(8'h11);
        put_frame(0, 48'hFFFF_0000_0000, 16'h0000);
        pulse_start();
        wait_done("R7 done");
        expect_found("R7 zero", 48'hFFFF_0000_0000, 1'b1, 16);

        // R8: stored FFFF does not match, address still reported
        fill(8'h11);
        put_frame(0, 48'hFFFF_0000_0000, 16'hFFFF);
        pulse_start();
        wait_done("R8 done");
        expect_found("R8 bad sum", 48'hFFFF_0000_0000, 1'b0, 16);

        // R2: restart mid-scan after six consumed bytes
        fill(8'h11);
        rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55;
        put_frame(12, 48'h0302_012B_0008, 16'h0578);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_start();
        wait_done("R2 done");
        expect_found("R2 restart", 48'h0302_012B_0008, 1'b1, 22);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule